// File: doc/BRIEF.md
# T1 Extended-Superframe CRC-6 and Alignment Monitor

This block watches a T1 extended-superframe bit stream that an upstream framer has already aligned. A bit strobe accompanies every bit. An F-bit flag and a frame number from 1 to 24 mark the framing-bit positions. The block checks the six alignment-pattern F bits and reports each mismatch. It flags a superframe that carries two or more such mismatches. It computes a CRC-6 over every superframe and checks it against the six CRC bits that arrive in the following superframe.

CRC-6 error events are accumulated over a fixed one-second window, marked by an external tick, to detect an excessive-error condition. Three things take the block out of sync: a dense run of alignment errors, an excessive CRC condition, or a manual request. Enable inputs decide which of these causes may also raise a reframe request to the external alignment search. While out of sync, all error detection is held off. An external resync pulse, carrying the newly found alignment position, brings the block back into sync. A change-of-alignment pulse is raised when that position differs from the one stored before.

Top module: `t1esf_mon`

## Requirements
- R1: The F bits of frames 4, 8, 12, 16, 20 and 24 are alignment bits, with expected values 0, 0, 1, 0, 1, 1 in that frame order. A mismatching one gives a one-cycle `fas_err` pulse in the cycle after its strobe.
- R2: If two or more alignment errors fall within one superframe (frames 1 to 24), `sev_fas_err` pulses in the cycle after the frame-24 F-bit strobe.
- R3: CRC-6 uses generator x^6+x+1, starts from zero, and covers every bit from the frame-1 F bit through the last bit of frame 24, with F bits taken as 1. The F bits of frames 2, 6, 10, 14, 18 and 22 carry the previous superframe's CRC, most significant bit first. A mismatch gives a `crc_err` pulse in the cycle after the frame-22 strobe. No comparison is made unless the previous superframe was seen whole while in sync.
- R4: CRC errors are counted in a saturating counter. On each `sec_tick` the count is compared with EXC_LIMIT (default 319). A count strictly above the limit gives an `exc_crc` pulse in the next cycle. Every tick clears the counter, and an error arriving with the tick counts toward the new window.
- R5: An excessive-CRC event always sets `oos` one cycle later. It raises `reframe_req` in the same cycle as `exc_crc` only when `reframe_en` and `crc_reframe_en` are both 1.
- R6: The block counts alignment errors among the last W alignment bits, with W = 4, 5 or 6 for `ratio_sel` = 0, 1 or 2 (3 acts as 2). When that count reaches two, `oos` is set one cycle after the `fas_err` pulse. `reframe_req` pulses together with that `fas_err` only if `reframe_en` is 1.
- R7: A 0-to-1 change on `manual_reframe` raises `reframe_req` in the next cycle, whatever the enables are, and sets `oos` the cycle after.
- R8: While `oos` is 1, no `fas_err`, `sev_fas_err`, `crc_err` or `exc_crc` event is produced. A `resync` pulse clears `oos` in the next cycle. A `resync` while `oos` is 0 has no effect.
- R9: A `resync` accepted while `oos` is 1 stores `align_pos`. If the stored value (0 after reset) differed, `cofa` pulses in the next cycle.
- R10: After reset all event outputs, `reframe_req` and `oos` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | A stream bit is present this cycle |
| bit_in | input | 1 | Stream bit value |
| f_pos | input | 1 | The present bit is the frame's F bit |
| frm_num | input | 5 | Frame number 1..24 within the superframe |
| sec_tick | input | 1 | One-cycle one-second window tick |
| reframe_en | input | 1 | Allow automatic reframe requests |
| crc_reframe_en | input | 1 | Allow excessive CRC to request a reframe |
| manual_reframe | input | 1 | Rising edge forces a reframe |
| ratio_sel | input | 2 | Alignment loss window select |
| resync | input | 1 | Alignment search found a new position |
| align_pos | input | POS_W | Newly found alignment position |
| fas_err | output | 1 | Alignment bit error pulse |
| sev_fas_err | output | 1 | Severe alignment error pulse |
| crc_err | output | 1 | CRC-6 error pulse |
| exc_crc | output | 1 | Excessive CRC pulse |
| oos | output | 1 | Out-of-sync level |
| reframe_req | output | 1 | Reframe request pulse |
| cofa | output | 1 | Change-of-alignment pulse |

## Verification
Every error event, together with `cofa`, is registered and appears exactly one cycle after the strobe, tick or resync that causes it. `reframe_req` for an alignment loss or an excessive CRC condition shares that cycle, and `oos` follows one cycle later. A manual request shows on `reframe_req` one cycle after the edge, with `oos` one cycle after that. The bench changes inputs on the falling edge and reads the outputs at the very next falling edge for each F bit, tick and resync. It also keeps running totals of every pulse, so that a pulse arriving in the wrong cycle still shows up in the per-superframe counts.

// File: rtl/t1esf_pkg.sv
package t1esf_pkg;
   localparam int FRM_W = 5;
   localparam int CRC_W = 6;
   // bit k: expected value of the alignment bit in frame 4*(k+1)
   localparam logic [5:0] FAS_EXP = 6'b110100;

   typedef logic [CRC_W-1:0] crc_t;

   // one serial step of division by x^6 + x + 1
   function automatic crc_t crc6_step(input crc_t r, input logic b);
      logic fb;
      fb = b ^ r[CRC_W-1];
      return {r[CRC_W-2:0], 1'b0} ^ (fb ? crc_t'(6'b000011) : crc_t'(0));
   endfunction
endpackage

// File: rtl/t1esf_fas_chk.sv
module t1esf_fas_chk
   import t1esf_pkg::*;
#(
   parameter int HIST = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             f_stb,
   input  logic [FRM_W-1:0] frm,
   input  logic             bit_in,
   input  logic [1:0]       ratio_sel,
   output logic             fas_err_o,
   output logic             sev_o,
   output logic             loss_o
);
   logic [HIST-1:0] hist, hist_n, win_mask;
   logic [1:0]      sf_cnt;
   logic [2:0]      idx;
   logic            is_fas, miss;
   int              win_len;

   if (HIST < 6) begin : g_bad_hist
      $error("HIST must be at least 6");
   end

   always_comb begin
      case (ratio_sel)
         2'd0:    win_len = 4;
         2'd1:    win_len = 5;
         default: win_len = 6;
      endcase
   end

   for (genvar k = 0; k < HIST; k++) begin : g_mask
      assign win_mask[k] = (k < win_len);
   end

   assign is_fas = act && f_stb && (frm[1:0] == 2'b00) && (frm != '0) && (frm <= FRM_W'(24));
   assign idx    = frm[4:2] - 3'd1;
   assign miss   = is_fas && (bit_in != FAS_EXP[idx]);
   assign hist_n = {hist[HIST-2:0], miss};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist      <= '0;
         sf_cnt    <= '0;
         fas_err_o <= 1'b0;
         sev_o     <= 1'b0;
         loss_o    <= 1'b0;
      end else begin
         fas_err_o <= miss;
         sev_o     <= 1'b0;
         loss_o    <= 1'b0;
         if (!act) begin
            hist   <= '0;
            sf_cnt <= '0;
         end else if (is_fas) begin
            hist   <= hist_n;
            loss_o <= miss && ($countones(hist_n & win_mask) >= 2);
            if (frm == FRM_W'(24)) begin
               sev_o  <= (sf_cnt >= 2'd2) || ((sf_cnt != 2'd0) && miss);
               sf_cnt <= '0;
            end else if (miss && sf_cnt != 2'd2) begin
               sf_cnt <= sf_cnt + 2'd1;
            end
         end
      end
   end

   p_err_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fas_err_o |-> $past(act && f_stb && frm[1:0] == 2'b00));
   p_sev_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sev_o |-> $past(f_stb && frm == FRM_W'(24)));
   p_loss_with_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      loss_o |-> fas_err_o);
endmodule

// File: rtl/t1esf_crc_chk.sv
module t1esf_crc_chk
   import t1esf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             bit_vld,
   input  logic             f_pos,
   input  logic [FRM_W-1:0] frm,
   input  logic             bit_in,
   output logic             crc_err_o
);
   crc_t       run, prev;
   logic [4:0] rx;
   logic       run_ok, prev_ok, crc_pos;

   assign crc_pos = (frm[1:0] == 2'b10) && (frm <= FRM_W'(22));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run       <= '0;
         prev      <= '0;
         rx        <= '0;
         run_ok    <= 1'b0;
         prev_ok   <= 1'b0;
         crc_err_o <= 1'b0;
      end else begin
         crc_err_o <= 1'b0;
         if (!act) begin
            run_ok  <= 1'b0;
            prev_ok <= 1'b0;
         end else if (bit_vld) begin
            if (f_pos && frm == FRM_W'(1)) begin
               prev    <= run;
               prev_ok <= run_ok;
               run     <= crc6_step('0, 1'b1);
               run_ok  <= 1'b1;
            end else begin
               run <= crc6_step(run, f_pos | bit_in);
            end
            if (f_pos && crc_pos) begin
               rx <= {rx[3:0], bit_in};
               if (frm == FRM_W'(22))
                  crc_err_o <= prev_ok && ({rx, bit_in} != prev);
            end
         end
      end
   end

   p_crc_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err_o |-> $past(act && bit_vld && f_pos && frm == FRM_W'(22)));
endmodule

// File: rtl/t1esf_exc_win.sv
module t1esf_exc_win #(
   parameter int LIMIT = 319
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic err_i,
   input  logic tick_i,
   output logic exc_o
);
   localparam int SAT = LIMIT + 1;
   localparam int CW  = $clog2(SAT + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
   localparam logic [CW-1:0] SAT_V = CW'(SAT);

   logic [CW-1:0] cnt;

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         exc_o <= 1'b0;
      end else begin
         exc_o <= 1'b0;
         if (tick_i) begin
            exc_o <= act && (cnt > LIM_V);
            cnt   <= err_i ? CW'(1) : '0;
         end else if (err_i && cnt != SAT_V) begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= SAT_V);
   p_exc_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |-> $past(tick_i));
endmodule

// File: rtl/t1esf_mon.sv
module t1esf_mon
   import t1esf_pkg::*;
#(
   parameter int EXC_LIMIT = 319,
   parameter int POS_W     = 8,
   parameter int HIST      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             f_pos,
   input  logic [FRM_W-1:0] frm_num,
   input  logic             sec_tick,
   input  logic             reframe_en,
   input  logic             crc_reframe_en,
   input  logic             manual_reframe,
   input  logic [1:0]       ratio_sel,
   input  logic             resync,
   input  logic [POS_W-1:0] align_pos,
   output logic             fas_err,
   output logic             sev_fas_err,
   output logic             crc_err,
   output logic             exc_crc,
   output logic             oos,
   output logic             reframe_req,
   output logic             cofa
);
   logic             oos_q, man_q, man_p, cofa_q, loss, act;
   logic [POS_W-1:0] pos_q;

   if (POS_W < 1) begin : g_bad_pos
      $error("POS_W must be positive");
   end

   assign act = !oos_q;

   t1esf_fas_chk #(.HIST(HIST)) u_fas (
      .clk(clk), .rst_n(rst_n), .act(act), .f_stb(bit_vld && f_pos),
      .frm(frm_num), .bit_in(bit_in), .ratio_sel(ratio_sel),
      .fas_err_o(fas_err), .sev_o(sev_fas_err), .loss_o(loss));

   t1esf_crc_chk u_crc (
      .clk(clk), .rst_n(rst_n), .act(act), .bit_vld(bit_vld), .f_pos(f_pos),
      .frm(frm_num), .bit_in(bit_in), .crc_err_o(crc_err));

   t1esf_exc_win #(.LIMIT(EXC_LIMIT)) u_exc (
      .clk(clk), .rst_n(rst_n), .act(act), .err_i(crc_err),
      .tick_i(sec_tick), .exc_o(exc_crc));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oos_q  <= 1'b0;
         man_q  <= 1'b0;
         man_p  <= 1'b0;
         cofa_q <= 1'b0;
         pos_q  <= '0;
      end else begin
         man_q  <= manual_reframe;
         man_p  <= manual_reframe && !man_q;
         cofa_q <= 1'b0;
         if (loss || exc_crc || man_p) begin
            oos_q <= 1'b1;
         end else if (resync && oos_q) begin
            oos_q  <= 1'b0;
            cofa_q <= (align_pos != pos_q);
            pos_q  <= align_pos;
         end
      end
   end

   assign reframe_req = (loss && reframe_en) || (exc_crc && reframe_en && crc_reframe_en) || man_p;
   assign oos  = oos_q;
   assign cofa = cofa_q;

   p_quiet_oos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oos_q) |-> !(fas_err || sev_fas_err || crc_err || exc_crc));
   p_loss_sets_oos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      loss |=> oos_q);
   p_exc_sets_oos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_crc |=> oos_q);
   p_rfr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reframe_req && !loss && !man_p) |-> (reframe_en && crc_reframe_en));
   p_manual_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (manual_reframe && !man_q) |=> reframe_req);
   p_cofa_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cofa_q |-> $past(resync && oos_q));
endmodule

// File: tb/sim_t1esf_mon.sv
module sim_t1esf_mon;
   localparam int LIM  = 2;
   localparam int WDOG = 100000;
   localparam logic [5:0] PAT = 6'b110100;
   // {mask[5:0], corrupt, exp_fas[2:0], exp_sev, exp_crc}
   localparam logic [11:0] TBL [7] = '{
      {6'b000000, 1'b1, 3'd0, 1'b0, 1'b0},
      {6'b000001, 1'b0, 3'd1, 1'b0, 1'b0},
      {6'b000000, 1'b1, 3'd0, 1'b0, 1'b1},
      {6'b100001, 1'b0, 3'd2, 1'b1, 1'b0},
      {6'b000000, 1'b1, 3'd0, 1'b0, 1'b1},
      {6'b001000, 1'b0, 3'd1, 1'b0, 1'b0},
      {6'b000000, 1'b0, 3'd0, 1'b0, 1'b0}};

   logic clk = 0, rst_n = 0;
   logic bit_vld = 0, bit_in = 0, f_pos = 0, sec_tick = 0;
   logic [4:0] frm_num = 0;
   logic reframe_en = 1, crc_reframe_en = 1, manual_reframe = 0, resync = 0;
   logic [1:0] ratio_sel = 0;
   logic [7:0] align_pos = 0;
   logic fas_err, sev_fas_err, crc_err, exc_crc, oos, reframe_req, cofa;

   int checks = 0, fails = 0;
   int m_fas = 0, m_sev = 0, m_crc = 0, m_rfr = 0;
   logic [5:0] brun = 0, bprev = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   t1esf_mon #(.EXC_LIMIT(LIM)) u0 (.*);

   always @(negedge clk) if (rst_n) begin
      m_fas += int'(fas_err);
      m_sev += int'(sev_fas_err);
      m_crc += int'(crc_err);
      m_rfr += int'(reframe_req);
   end

   function automatic logic [5:0] step(input logic [5:0] r, input logic b);
      return {r[4:0], 1'b0} ^ ((b ^ r[5]) ? 6'b000011 : 6'b000000);
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(input logic f, input logic [4:0] fr, input logic b);
      bit_vld = 1; f_pos = f; frm_num = fr; bit_in = b;
      @(negedge clk);
      bit_vld = 0; f_pos = 0;
   endtask

   task automatic send_sf(input logic [5:0] mask, input logic corrupt, input logic chk,
                          input logic esev, input logic ecrc);
      logic [5:0] sent;
      logic fb;
      for (int fr = 1; fr <= 24; fr++) begin
         if (fr == 1) begin
            bprev = brun;
            brun  = 6'd0;
         end
         sent = bprev ^ (corrupt ? 6'b000100 : 6'b000000);
         if (fr % 4 == 0)      fb = PAT[fr/4-1] ^ mask[fr/4-1];
         else if (fr % 4 == 2) fb = sent[5 - (fr-2)/4];
         else                  fb = lfsr[0];
         brun = step(brun, 1'b1);
         push(1'b1, 5'(fr), fb);
         if (chk) begin
            if (fr % 4 == 0) check(fas_err == mask[fr/4-1], "R1 fas_err", int'(fas_err), int'(mask[fr/4-1]));
            if (fr == 22)    check(crc_err == ecrc, "R3 crc_err", int'(crc_err), int'(ecrc));
            if (fr == 24)    check(sev_fas_err == esev, "R2 sev_fas_err", int'(sev_fas_err), int'(esev));
         end
         for (int p = 0; p < 8; p++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            brun = step(brun, lfsr[0]);
            push(1'b0, 5'(fr), lfsr[0]);
         end
      end
      @(negedge clk);
   endtask

   task automatic tick(input logic exp_exc, input logic exp_rfr);
      sec_tick = 1;
      @(negedge clk);
      sec_tick = 0;
      check(exc_crc == exp_exc, "R4 exc_crc", int'(exc_crc), int'(exp_exc));
      check(reframe_req == exp_rfr, "R5 reframe_req on excess", int'(reframe_req), int'(exp_rfr));
      @(negedge clk);
      check(oos == exp_exc, "R5 oos after excess", int'(oos), int'(exp_exc));
   endtask

   task automatic do_resync(input logic [7:0] p, input logic exp_cofa);
      resync = 1; align_pos = p;
      @(negedge clk);
      resync = 0;
      check(cofa == exp_cofa, "R9 cofa", int'(cofa), int'(exp_cofa));
      check(oos == 1'b0, "R8 oos after resync", int'(oos), 0);
      @(negedge clk);
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      checks++; fails++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      finish_up();
   end

   initial begin
      int f0, s0, c0, r0;
      repeat (3) @(negedge clk);
      check({fas_err, sev_fas_err, crc_err, exc_crc, oos, reframe_req, cofa} == 7'd0,
            "R10 reset outputs", int'({fas_err, sev_fas_err, crc_err, exc_crc, oos, reframe_req, cofa}), 0);
      rst_n = 1;
      @(negedge clk);
      check(oos == 0, "R10 oos after reset", int'(oos), 0);

      // table walk: alignment, severe and CRC cases, window 2-of-4
      foreach (TBL[i]) begin
         f0 = m_fas; s0 = m_sev; c0 = m_crc;
         send_sf(TBL[i][11:6], TBL[i][5], 1'b1, TBL[i][1], TBL[i][0]);
         check(m_fas - f0 == int'(TBL[i][4:2]), "R1 fas count", m_fas - f0, int'(TBL[i][4:2]));
         check(m_sev - s0 == int'(TBL[i][1]), "R2 sev count", m_sev - s0, int'(TBL[i][1]));
         check(m_crc - c0 == int'(TBL[i][0]), "R3 crc count", m_crc - c0, int'(TBL[i][0]));
         check(oos == 0, "R6 no loss in table", int'(oos), 0);
      end

      // R4 boundary: two errors, limit 2 -> not excessive
      tick(1'b0, 1'b0);

      // R4/R5: three errors, crc reframe disabled
      crc_reframe_en = 0;
      for (int k = 0; k < 3; k++) send_sf(6'd0, 1'b1, 1'b1, 1'b0, 1'b1);
      tick(1'b1, 1'b0);

      // R8: suspended while out of sync
      f0 = m_fas; s0 = m_sev; c0 = m_crc;
      send_sf(6'b111111, 1'b1, 1'b0, 1'b0, 1'b0);
      check(m_fas - f0 == 0, "R8 no fas while oos", m_fas - f0, 0);
      check(m_sev - s0 == 0, "R8 no sev while oos", m_sev - s0, 0);
      check(m_crc - c0 == 0, "R8 no crc while oos", m_crc - c0, 0);
      do_resync(8'd3, 1'b1);

      // R3: first superframe after resync has nothing to compare
      send_sf(6'd0, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) send_sf(6'd0, 1'b1, 1'b1, 1'b0, 1'b1);
      crc_reframe_en = 1;
      tick(1'b1, 1'b1);
      do_resync(8'd3, 1'b0);

      // R8/R9: resync while in sync is ignored
      resync = 1; align_pos = 8'd7;
      @(negedge clk);
      resync = 0;
      check(cofa == 0, "R9 ignored resync cofa", int'(cofa), 0);
      check(oos == 0, "R8 ignored resync oos", int'(oos), 0);

      // R6: adjacent errors, reframe disabled
      reframe_en = 0;
      f0 = m_fas; s0 = m_sev; r0 = m_rfr;
      send_sf(6'b000011, 1'b0, 1'b0, 1'b0, 1'b0);
      check(m_fas - f0 == 2, "R6 fas before loss", m_fas - f0, 2);
      check(m_sev - s0 == 0, "R8 sev suppressed after loss", m_sev - s0, 0);
      check(m_rfr - r0 == 0, "R6 no reframe when disabled", m_rfr - r0, 0);
      check(oos == 1, "R6 oos after loss", int'(oos), 1);
      do_resync(8'd7, 1'b1);

      // R6 window boundary: errors 4 apart with window 4 keep sync
      reframe_en = 1;
      send_sf(6'd0, 1'b0, 1'b1, 1'b0, 1'b0);
      send_sf(6'b010001, 1'b0, 1'b1, 1'b1, 1'b0);
      check(oos == 0, "R6 window 4 keeps sync", int'(oos), 0);
      send_sf(6'd0, 1'b0, 1'b1, 1'b0, 1'b0);
      ratio_sel = 2'd1;
      r0 = m_rfr;
      send_sf(6'b010001, 1'b0, 1'b0, 1'b0, 1'b0);
      check(m_rfr - r0 == 1, "R6 reframe with window 5", m_rfr - r0, 1);
      check(oos == 1, "R6 oos with window 5", int'(oos), 1);

      // R7: manual request while out of sync, enables off
      reframe_en = 0; crc_reframe_en = 0;
      manual_reframe = 1;
      @(negedge clk);
      check(reframe_req == 1, "R7 manual reframe_req", int'(reframe_req), 1);
      manual_reframe = 0;
      @(negedge clk);
      do_resync(8'd7, 1'b0);

      // R7: manual request in sync, held high
      r0 = m_rfr;
      manual_reframe = 1;
      @(negedge clk);
      check(reframe_req == 1, "R7 manual edge", int'(reframe_req), 1);
      @(negedge clk);
      check(oos == 1, "R7 oos after manual", int'(oos), 1);
      repeat (3) @(negedge clk);
      check(m_rfr - r0 == 1, "R7 single pulse per edge", m_rfr - r0, 1);
      manual_reframe = 0;

      finish_up();
   end
endmodule